// File: doc/BRIEF.md
# Software Interrupt Request Sequencer

This block sits next to a processor's instruction decoder and converts trap-style instructions into interrupt requests for the core's interrupt-entry logic. The decoder gives it a one-cycle pulse for each of four instructions: the undefined-opcode trap, the conditional overflow trap, the breakpoint, and the numbered software interrupt. The numbered interrupt also carries a 6-bit number. The block picks one request and presents it to the core as a single-cycle strobe with a vector identifier. It then holds the identifier until the core acknowledges it.

The block also drives the stack-select flag the core must use. For the three fixed traps and for numbered interrupts 0 to 31, the current user-stack flag is saved and the output is forced to the interrupt stack (0) while the request is presented. For numbers 32 to 63 the current selection passes through untouched. A return-from-interrupt pulse makes the output carry the flag saved by the matching entry. A small last-in-first-out store of entry frames keeps nested entries correct.

Software requests cannot be masked: there is no enable or priority input that could hold them back. Vector fetch, register pushes and peripheral arbitration belong to other blocks.

Top module: `swi_sequencer`

## Requirements
- R1: While reset is low and in the first cycle after it, `req_o` is 0 and `vec_o` is 0, and the entry store is empty.
- R2: An undefined-opcode pulse always produces a request with vector identifier 64 (0x40); no input can suppress it.
- R3: An overflow-trap pulse produces a request with identifier 65 (0x41) only when `ovf_flag_i` is 1; with the flag at 0 it produces no request and saves nothing.
- R4: A breakpoint pulse always produces a request with identifier 66 (0x42).
- R5: A numbered-interrupt pulse with number n (0 to 63) produces a request with identifier n, upper bit 0, so numbers 4 to 31 land on the same identifiers a peripheral source would use.
- R6: Pulses in the same cycle are resolved in the fixed order undefined, overflow (only if the flag is 1), breakpoint, numbered; only the winner is requested.
- R7: `req_o` is high for exactly the one cycle after the edge that accepts a request. `vec_o` stays unchanged from then until the acknowledge is sampled.
- R8: A request accepted while an earlier one is unacknowledged waits in a one-entry slot. It is presented in the cycle after the edge where `ack_i` is sampled high.
- R9: For the three fixed traps and numbered interrupts 0 to 31, `stk_user_o` is 0 during the request cycle. The value of `user_stk_i` at the accepting edge is saved as a frame that will restore it.
- R10: For numbered interrupts 32 to 63, `stk_user_o` equals `user_stk_i` during the request cycle. The frame pushed for such an entry restores nothing.
- R11: While `ret_i` is high, `stk_user_o` carries the saved flag of the most recent frame if that frame restores, and `user_stk_i` otherwise. The frame is removed at the next edge.
- R12: The frame store is four levels deep and last-in-first-out. A push onto a full store discards the oldest frame. A return with the store empty passes `user_stk_i` through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_undef_i | input | 1 | Undefined-opcode trap pulse |
| trap_ovf_i | input | 1 | Conditional overflow trap pulse |
| trap_brk_i | input | 1 | Breakpoint pulse |
| trap_int_i | input | 1 | Numbered software interrupt pulse |
| int_num_i | input | 6 | Number carried by the numbered interrupt |
| ovf_flag_i | input | 1 | Current overflow flag |
| user_stk_i | input | 1 | Current user-stack select flag |
| ack_i | input | 1 | Core acknowledges the presented request |
| ret_i | input | 1 | Return-from-interrupt pulse |
| req_o | output | 1 | Single-cycle request strobe |
| vec_o | output | 7 | Vector identifier of the presented request |
| stk_user_o | output | 1 | Stack-select flag the core must apply |

## Verification
The assertions assume the decoder never issues a trap while a request is outstanding and the waiting slot is already full. They also assume a return pulse never coincides with a request cycle. The random stimulus respects both by acknowledging every request before issuing the next trap. Returns are only issued between complete entry sequences. One directed case places exactly one extra trap into the waiting slot. Within these limits, the bench keeps its own model of the frame store and predicts every vector and stack-select value. Nesting deeper than four levels and returns on an empty store are included.

// File: rtl/swi_pkg.sv
// Shared constants and types for the software interrupt sequencer.
// Assumes a 6-bit interrupt number; fixed traps use identifiers just above it.
package swi_pkg;
    localparam int NUM_W = 6;
    localparam int VEC_W = NUM_W + 1;
    localparam logic [VEC_W-1:0] VEC_UNDEF = VEC_W'(1 << NUM_W);
    localparam logic [VEC_W-1:0] VEC_OVF   = VEC_W'((1 << NUM_W) + 1);
    localparam logic [VEC_W-1:0] VEC_BRK   = VEC_W'((1 << NUM_W) + 2);

    // One request: the identifier and whether it switches to the interrupt stack.
    typedef struct packed {
        logic             save;
        logic [VEC_W-1:0] vec;
    } swi_req_t;

    // One entry frame: occupied, restores on return, saved flag value.
    typedef struct packed {
        logic valid;
        logic saved;
        logic flag;
    } flag_frame_t;
endpackage

// File: rtl/swi_arbiter.sv
// Fixed-order selection among trap pulses arriving in one cycle.
// Assumes pulses are single-cycle; purely combinational.
module swi_arbiter
    import swi_pkg::*;
(
    input  logic             trap_undef_i,
    input  logic             trap_ovf_i,
    input  logic             trap_brk_i,
    input  logic             trap_int_i,
    input  logic [NUM_W-1:0] int_num_i,
    input  logic             ovf_flag_i,
    output logic             cand_v_o,
    output swi_req_t         cand_o
);
    // Pick the winner: undefined, live overflow, breakpoint, numbered.
    always_comb begin
        cand_v_o = 1'b1;
        cand_o   = '{save: 1'b1, vec: VEC_UNDEF};
        if (trap_undef_i) begin
            cand_o.vec = VEC_UNDEF;
        end else if (trap_ovf_i && ovf_flag_i) begin
            cand_o.vec = VEC_OVF;
        end else if (trap_brk_i) begin
            cand_o.vec = VEC_BRK;
        end else if (trap_int_i) begin
            cand_o.vec  = {1'b0, int_num_i};
            cand_o.save = ~int_num_i[NUM_W-1];
        end else begin
            cand_v_o = 1'b0;
        end
    end
endmodule

// File: rtl/swi_issue.sv
// Presents requests to the core one at a time with a one-entry waiting slot.
// Assumes no new trap while busy and the slot is already full.
module swi_issue
    import swi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cand_v_i,
    input  swi_req_t cand_i,
    input  logic     ack_i,
    output logic     req_o,
    output swi_req_t cur_o,
    output logic     issue_o,
    output logic     issue_save_o,
    output logic     free_o,
    output logic     slot_v_o
);
    logic     busy_q;
    logic     slot_v_q;
    swi_req_t slot_q;
    logic     req_q;
    swi_req_t cur_q;
    swi_req_t next_req;

    // The core can take a request when idle or acknowledging this cycle.
    assign free_o = ~busy_q | ack_i;

    // Waiting slot takes precedence over a fresh candidate.
    always_comb begin
        next_req     = slot_v_q ? slot_q : cand_i;
        issue_o      = free_o & (slot_v_q | cand_v_i);
        issue_save_o = next_req.save;
    end

    // Track busy state, the waiting slot and the presented request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            slot_v_q <= 1'b0;
            slot_q   <= '0;
            req_q    <= 1'b0;
            cur_q    <= '0;
        end else begin
            req_q <= issue_o;
            if (issue_o) begin
                cur_q  <= next_req;
                busy_q <= 1'b1;
            end else if (ack_i) begin
                busy_q <= 1'b0;
            end
            if (issue_o && slot_v_q) begin
                slot_v_q <= cand_v_i;
                slot_q   <= cand_i;
            end else if (!free_o && cand_v_i && !slot_v_q) begin
                slot_v_q <= 1'b1;
                slot_q   <= cand_i;
            end
        end
    end

    assign req_o    = req_q;
    assign cur_o    = cur_q;
    assign slot_v_o = slot_v_q;
endmodule

// File: rtl/swi_flag_stack.sv
// Last-in-first-out store of entry frames holding the saved user-stack flag.
// Assumes push and pop never occur in the same cycle; full push drops oldest.
module swi_flag_stack
    import swi_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_i,
    input  flag_frame_t push_frame_i,
    input  logic        pop_i,
    output flag_frame_t top_o
);
    localparam int LAST = DEPTH - 1;

    flag_frame_t frame_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_level
        flag_frame_t from_above;
        flag_frame_t from_below;
        if (g == 0) begin : g_head
            assign from_above = push_frame_i;
        end else begin : g_body
            assign from_above = frame_q[g-1];
        end
        if (g == LAST) begin : g_tail
            assign from_below = '0;
        end else begin : g_inner
            assign from_below = frame_q[g+1];
        end
        // Shift toward the bottom on push, toward the top on pop.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                frame_q[g] <= '0;
            end else if (push_i) begin
                frame_q[g] <= from_above;
            end else if (pop_i) begin
                frame_q[g] <= from_below;
            end
        end
    end

    assign top_o = frame_q[0];
endmodule

// File: rtl/swi_sequencer.sv
// Software interrupt request sequencer: selects trap requests, presents them
// to the core and drives the stack-select flag across entry and return.
// Assumes ret_i never coincides with a request cycle.
module swi_sequencer
    import swi_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_undef_i,
    input  logic             trap_ovf_i,
    input  logic             trap_brk_i,
    input  logic             trap_int_i,
    input  logic [NUM_W-1:0] int_num_i,
    input  logic             ovf_flag_i,
    input  logic             user_stk_i,
    input  logic             ack_i,
    input  logic             ret_i,
    output logic             req_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             stk_user_o
);
    logic        cand_v;
    swi_req_t    cand;
    swi_req_t    cur;
    logic        issue;
    logic        issue_save;
    logic        issue_free;
    logic        slot_valid;
    flag_frame_t top;
    flag_frame_t new_frame;

    swi_arbiter u_arb (
        .trap_undef_i(trap_undef_i), .trap_ovf_i(trap_ovf_i),
        .trap_brk_i(trap_brk_i),     .trap_int_i(trap_int_i),
        .int_num_i(int_num_i),       .ovf_flag_i(ovf_flag_i),
        .cand_v_o(cand_v),           .cand_o(cand)
    );

    swi_issue u_issue (
        .clk(clk), .rst_n(rst_n), .cand_v_i(cand_v), .cand_i(cand),
        .ack_i(ack_i), .req_o(req_o), .cur_o(cur), .issue_o(issue),
        .issue_save_o(issue_save), .free_o(issue_free), .slot_v_o(slot_valid)
    );

    // Frame pushed on every entry; only saving entries restore on return.
    assign new_frame = '{valid: 1'b1, saved: issue_save, flag: user_stk_i};

    swi_flag_stack #(.DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .push_i(issue), .push_frame_i(new_frame),
        .pop_i(ret_i), .top_o(top)
    );

    // Choose restored, forced or pass-through stack selection.
    always_comb begin
        if (ret_i) begin
            stk_user_o = (top.valid && top.saved) ? top.flag : user_stk_i;
        end else if (req_o && cur.save) begin
            stk_user_o = 1'b0;
        end else begin
            stk_user_o = user_stk_i;
        end
    end

    assign vec_o = cur.vec;
endmodule

// File: rtl/swi_sequencer_chk.sv
// Property checker for the software interrupt sequencer, attached by bind.
// Assumes the input protocol stated in the brief.
module swi_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       trap_undef_i,
    input logic       trap_ovf_i,
    input logic       trap_brk_i,
    input logic       trap_int_i,
    input logic       ovf_flag_i,
    input logic       user_stk_i,
    input logic       ack_i,
    input logic       ret_i,
    input logic       req_o,
    input logic [6:0] vec_o,
    input logic       stk_user_o,
    input logic       issue_free,
    input logic       slot_valid
);
    logic any_trap;
    assign any_trap = trap_undef_i | (trap_ovf_i & ovf_flag_i) | trap_brk_i | trap_int_i;

    p_undef_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_undef_i && issue_free && !slot_valid |=> req_o && vec_o == 7'h40);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_ovf_i && !ovf_flag_i && !trap_undef_i && !trap_brk_i && !trap_int_i
        && issue_free && !slot_valid |=> !req_o);

    p_brk_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_brk_i && !trap_undef_i && !(trap_ovf_i && ovf_flag_i)
        && issue_free && !slot_valid |=> req_o && vec_o == 7'h42);

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && !ack_i |=> !req_o);

    p_vec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && !ack_i |=> $stable(vec_o));

    p_no_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(any_trap && !issue_free && slot_valid));

    p_force_isp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && !ret_i && (vec_o[6] || !vec_o[5]) |-> !stk_user_o);

    p_keep_stack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && !ret_i && vec_o[6:5] == 2'b01 |-> stk_user_o == user_stk_i);

    p_ret_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ret_i && req_o));
endmodule

bind swi_sequencer swi_sequencer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .trap_undef_i(trap_undef_i), .trap_ovf_i(trap_ovf_i),
    .trap_brk_i(trap_brk_i), .trap_int_i(trap_int_i), .ovf_flag_i(ovf_flag_i),
    .user_stk_i(user_stk_i), .ack_i(ack_i), .ret_i(ret_i), .req_o(req_o),
    .vec_o(vec_o), .stk_user_o(stk_user_o), .issue_free(issue_free),
    .slot_valid(slot_valid)
);

// File: tb/sim_swi_sequencer.sv
// Self-checking bench for swi_sequencer: directed corners plus seeded random.
module sim_swi_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trap_undef_i = 0, trap_ovf_i = 0, trap_brk_i = 0, trap_int_i = 0;
    logic [5:0] int_num_i = 0;
    logic       ovf_flag_i = 0, user_stk_i = 0, ack_i = 0, ret_i = 0;
    logic       req_o;
    logic [6:0] vec_o;
    logic       stk_user_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Model of the frame store: index 0 is the newest frame.
    bit m_valid [4];
    bit m_saved [4];
    bit m_flag  [4];

    always #5 clk = ~clk;

    swi_sequencer u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected winner of a cycle's pulses.
    function automatic void pick(input bit u, o, b, t, input bit [5:0] n, input bit f,
                                 output bit v, output int vec, output bit save);
        v = 1; save = 1;
        if (u)          vec = 64;
        else if (o && f) vec = 65;
        else if (b)     vec = 66;
        else if (t) begin vec = int'(n); save = (n < 32); end
        else begin v = 0; vec = 0; end
    endfunction

    function automatic void m_push(input bit saved, input bit flag);
        for (int k = 3; k > 0; k--) begin
            m_valid[k] = m_valid[k-1]; m_saved[k] = m_saved[k-1]; m_flag[k] = m_flag[k-1];
        end
        m_valid[0] = 1; m_saved[0] = saved; m_flag[0] = flag;
    endfunction

    function automatic void m_pop();
        for (int k = 0; k < 3; k++) begin
            m_valid[k] = m_valid[k+1]; m_saved[k] = m_saved[k+1]; m_flag[k] = m_flag[k+1];
        end
        m_valid[3] = 0; m_saved[3] = 0; m_flag[3] = 0;
    endfunction

    // One trap instruction, its request check and an acknowledge after d cycles.
    task automatic do_trap(input bit u, o, b, t, input bit [5:0] n, input bit f,
                           input bit us, input int d, input string tag);
        bit v, save; int ev;
        pick(u, o, b, t, n, f, v, ev, save);
        @(negedge clk);
        trap_undef_i = u; trap_ovf_i = o; trap_brk_i = b; trap_int_i = t;
        int_num_i = n; ovf_flag_i = f; user_stk_i = us;
        @(negedge clk);
        chk(req_o == v, {tag, " req"}, req_o, v);
        trap_undef_i = 0; trap_ovf_i = 0; trap_brk_i = 0; trap_int_i = 0;
        if (v) begin
            chk(vec_o == ev, {tag, " vec R5 R6"}, vec_o, ev);
            chk(stk_user_o == (save ? 1'b0 : us), {tag, " stk R9 R10"}, stk_user_o, save ? 0 : us);
            m_push(save, us);
            for (int k = 0; k < d; k++) begin
                @(negedge clk);
                chk(req_o == 0, "R7 pulse", req_o, 0);
                chk(vec_o == ev, "R7 hold", vec_o, ev);
            end
            ack_i = 1;
            @(negedge clk);
            ack_i = 0;
            chk(req_o == 0, "R7 after ack", req_o, 0);
        end else begin
            chk(stk_user_o == us, {tag, " stk idle"}, stk_user_o, us);
        end
    endtask

    // One return: predict the restored flag and pop the model.
    task automatic do_ret(input bit us, input string tag);
        bit e;
        @(negedge clk);
        ret_i = 1; user_stk_i = us;
        #1;
        e = (m_valid[0] && m_saved[0]) ? m_flag[0] : us;
        chk(stk_user_o == e, tag, stk_user_o, e);
        m_pop();
        @(negedge clk);
        ret_i = 0;
    endtask

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        for (int k = 0; k < 4; k++) begin m_valid[k] = 0; m_saved[k] = 0; m_flag[k] = 0; end
        repeat (3) @(negedge clk);
        chk(req_o == 0, "R1 req in reset", req_o, 0);
        chk(vec_o == 0, "R1 vec in reset", vec_o, 0);
        rst_n = 1;
        @(negedge clk);
        chk(req_o == 0, "R1 req after reset", req_o, 0);
        do_ret(1, "R1 R12 empty store return");

        // Directed corners.
        do_trap(1, 1, 1, 1, 6'd5, 1, 1, 0, "R2 R6 all at once");
        do_trap(0, 1, 1, 1, 6'd7, 0, 1, 1, "R6 overflow dead, break wins");
        do_trap(0, 1, 0, 0, 6'd0, 0, 1, 0, "R3 flag clear");
        do_trap(0, 1, 0, 1, 6'd9, 1, 0, 2, "R3 R6 overflow live");
        do_trap(0, 0, 1, 0, 6'd0, 0, 1, 0, "R4 break");
        do_trap(0, 0, 0, 1, 6'd31, 0, 1, 0, "R5 R9 int 31");
        do_trap(0, 0, 0, 1, 6'd32, 0, 1, 3, "R5 R10 int 32");
        do_trap(0, 0, 0, 1, 6'd63, 0, 0, 0, "R5 R10 int 63");
        for (int k = 0; k < 6; k++) do_ret(k[0], "R11 R12 unwind");

        // R8: second trap while the first waits for acknowledge.
        @(negedge clk);
        trap_undef_i = 1; user_stk_i = 1;
        @(negedge clk);
        trap_undef_i = 0;
        chk(req_o == 1 && vec_o == 64, "R8 first request", vec_o, 64);
        m_push(1, 1);
        trap_brk_i = 1; user_stk_i = 0;
        @(negedge clk);
        trap_brk_i = 0;
        chk(req_o == 0, "R8 held off", req_o, 0);
        @(negedge clk);
        chk(req_o == 0 && vec_o == 64, "R8 still held", vec_o, 64);
        ack_i = 1;
        @(negedge clk);
        ack_i = 0;
        chk(req_o == 1 && vec_o == 66, "R8 waiting request issued", vec_o, 66);
        chk(stk_user_o == 0, "R8 R9 forced stack", stk_user_o, 0);
        m_push(1, 0);
        ack_i = 1;
        @(negedge clk);
        ack_i = 0;
        do_ret(1, "R11 restore after wait");
        do_ret(0, "R11 restore first");

        // R12: five nested entries then five returns; oldest frame discarded.
        for (int k = 0; k < 5; k++) do_trap(0, 0, 0, 1, 6'(k + 2), 0, k[0], 0, "R12 nest");
        for (int k = 0; k < 5; k++) do_ret(1'b1, "R12 unnest");

        // Seeded random mix of entries and returns.
        for (int it = 0; it < 400; it++) begin
            if ($urandom_range(0, 9) < 7)
                do_trap(1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 3) == 0),
                        1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
                        6'($urandom_range(0, 63)), 1'($urandom_range(0, 1)),
                        1'($urandom_range(0, 1)), $urandom_range(0, 3), "R2-random");
            else
                do_ret(1'($urandom_range(0, 1)), "R11 random return");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule